// File: doc/BRIEF.md
# Single-Slope PWM Timer with Two Compare Channels

This block is an up-counting timer that produces pulse-width-modulated waveforms on two output pins. A system-clock divider turns the core clock into timer ticks. A counter climbs on each tick until it equals its ceiling, then restarts from zero on the following tick. The ceiling is either the full 8-bit range or the value held in compare channel A. Each channel compares the counter against its own active compare value, drives its pin high or low according to a polarity field, and raises a match flag.

Software writes compare values into a holding stage. They reach the comparators only when the counter restarts, so a period never sees a half-updated duty. An overflow flag marks each restart. All three flags clear when the matching clear input is pulsed. The two per-channel output state machines (states `PIN_LOW` and `PIN_HIGH`) and the run controller (states `RUN_HALT` and `RUN_ACTIVE`) make up the sequential behaviour.

Run controller transitions: `RUN_HALT` to `RUN_ACTIVE` when the divider select is nonzero and the waveform mode is 3 or 7; `RUN_ACTIVE` to `RUN_HALT` when either condition fails. Pin transitions: restart tick to the restart level, match tick to the match level, and any cycle with polarity field 0 or 1 to `PIN_LOW`.

Top module: `fpwm_timer`

## Requirements
- R1: On every tick the counter advances by one. On the tick taken while it equals the ceiling it returns to 0 instead, so one period is ceiling+1 ticks.
- R2: With `wave_mode` 3 the ceiling is 255. With `wave_mode` 7 it is the active compare value of channel A. With any other `wave_mode` the counter holds its value.
- R3: `ovf_flag` becomes 1 on the clock edge of the tick taken while the counter equals the ceiling, which is the edge where the counter returns to 0.
- R4: With polarity field 2 (non-inverted), a pin is 1 exactly while the counter lies in 0..compare. A compare value at or above the ceiling gives a constant 1. A compare value of 0 gives a one-tick pulse per period.
- R5: With polarity field 3 (inverted), a pin is the complement of R4. A compare value at or above the ceiling gives a constant 0.
- R6: With polarity field 0 or 1, the pin is 0.
- R7: A channel's match flag becomes 1 on the edge of a tick taken while the counter equals that channel's active compare value.
- R8: A 1 on a flag's clear input clears that flag at the next edge. A set event at the same edge wins over the clear.
- R9: A written compare value goes into a holding stage and becomes active only at the next restart edge. Before that edge, the pins follow the old value.
- R10: `clk_sel` values 1 to 7 give one tick every 1, 8, 32, 64, 128, 256 or 1024 clocks. A value of 0 gives no ticks, so the counter holds.
- R11: Any change of `clk_sel` restarts the divider. The first tick after the change comes exactly N clocks after the edge that first sees the new value, where N is the new divisor.
- R12: While `rst_n` is low, the counter, all flags, both pins and all compare stages are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_sel | input | 3 | Divider select, 0 stops |
| wave_mode | input | 3 | 3 = fixed ceiling, 7 = ceiling from channel A |
| cmode_a | input | 2 | Channel A polarity field |
| cmode_b | input | 2 | Channel B polarity field |
| cmp_a_we | input | 1 | Write strobe for channel A holding stage |
| cmp_a_wdata | input | 8 | Channel A compare value |
| cmp_b_we | input | 1 | Write strobe for channel B holding stage |
| cmp_b_wdata | input | 8 | Channel B compare value |
| ovf_clr | input | 1 | Clear overflow flag |
| cmpa_clr | input | 1 | Clear channel A match flag |
| cmpb_clr | input | 1 | Clear channel B match flag |
| count | output | 8 | Counter value |
| pwm_a | output | 1 | Channel A waveform |
| pwm_b | output | 1 | Channel B waveform |
| ovf_flag | output | 1 | Restart flag |
| cmpa_flag | output | 1 | Channel A match flag |
| cmpb_flag | output | 1 | Channel B match flag |

## Verification
The bench targets these corner cases:
- **Compare value at an extreme.** It counts high ticks per period with compare values at 0, at the ceiling and above it. A design that let the match win over the restart would show a one-tick glitch where a constant level is due. A design with an off-by-one window would report ceiling or ceiling+2 instead of ceiling+1.
- **Holding stage.** A duty is rewritten mid-period. A design that skipped the holding stage would change the pin in that same period.
- **Flag clear against a set.** A flag clear is pulsed at the very edge that sets the flag. A design where the clear wins would drop the event.
- **Divider select change.** The select is changed mid-phase. A divider that kept its old count would tick a few clocks early.

// File: rtl/fpwm_pkg.sv
package fpwm_pkg;

    localparam int PS_W = 10;

    localparam logic [2:0] WM_FIXED  = 3'd3;
    localparam logic [2:0] WM_VARTOP = 3'd7;

    typedef enum logic [1:0] {
        CM_OFF0   = 2'd0,
        CM_OFF1   = 2'd1,
        CM_NONINV = 2'd2,
        CM_INV    = 2'd3
    } cmp_mode_e;

    typedef enum logic {
        RUN_HALT   = 1'b0,
        RUN_ACTIVE = 1'b1
    } run_state_e;

    typedef enum logic {
        PIN_LOW  = 1'b0,
        PIN_HIGH = 1'b1
    } pin_state_e;

    // divider terminal count (divisor minus one) per select value
    function automatic logic [PS_W-1:0] ps_limit(input logic [2:0] sel);
        logic [PS_W-1:0] lim;
        unique case (sel)
            3'd1:    lim = PS_W'(0);
            3'd2:    lim = PS_W'(7);
            3'd3:    lim = PS_W'(31);
            3'd4:    lim = PS_W'(63);
            3'd5:    lim = PS_W'(127);
            3'd6:    lim = PS_W'(255);
            3'd7:    lim = PS_W'(1023);
            default: lim = PS_W'(0);
        endcase
        return lim;
    endfunction

endpackage

// File: rtl/fpwm_prescaler.sv
module fpwm_prescaler
    import fpwm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] sel,
    output logic       tick
);

    logic [2:0]      sel_q;
    logic [PS_W-1:0] pc;
    logic [PS_W-1:0] lim;
    logic            sel_chg;
    logic            on;

    always_comb begin
        lim     = ps_limit(sel);
        sel_chg = (sel != sel_q);
        on      = (sel != 3'd0);
        tick    = on && !sel_chg && (pc == lim);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= 3'd0;
            pc    <= '0;
        end else begin
            sel_q <= sel;
            if (sel_chg || tick || !on)
                pc <= '0;
            else
                pc <= pc + 1'b1;
        end
    end

endmodule

// File: rtl/fpwm_counter.sv
module fpwm_counter
    import fpwm_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int NCH   = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      tick,
    input  logic                      clk_on,
    input  logic [2:0]                wave_mode,
    input  logic [NCH-1:0]            cmp_we,
    input  logic [NCH-1:0][CNT_W-1:0] cmp_wdata,
    input  logic                      ovf_clr,
    output logic [CNT_W-1:0]          count,
    output logic                      step,
    output logic                      wrap,
    output logic [NCH-1:0][CNT_W-1:0] cmp_act,
    output logic                      ovf_flag
);

    run_state_e          state, state_nxt;
    logic                enable;
    logic [CNT_W-1:0]    top;
    logic [CNT_W-1:0]    cmp_buf [NCH];

    // run controller: state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= RUN_HALT;
        else        state <= state_nxt;
    end

    // run controller: transitions
    always_comb begin
        enable    = clk_on && ((wave_mode == WM_FIXED) || (wave_mode == WM_VARTOP));
        state_nxt = state;
        unique case (state)
            RUN_HALT:   if (enable)  state_nxt = RUN_ACTIVE;
            RUN_ACTIVE: if (!enable) state_nxt = RUN_HALT;
        endcase
    end

    // run controller: outputs
    always_comb begin
        top  = (wave_mode == WM_VARTOP) ? cmp_act[0] : {CNT_W{1'b1}};
        step = tick && enable && (state == RUN_ACTIVE);
        wrap = step && (count == top);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       count <= '0;
        else if (wrap)    count <= '0;
        else if (step)    count <= count + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NCH; i++) begin
                cmp_buf[i] <= '0;
                cmp_act[i] <= '0;
            end
        end else begin
            for (int i = 0; i < NCH; i++) begin
                if (cmp_we[i]) cmp_buf[i] <= cmp_wdata[i];
                if (wrap)      cmp_act[i] <= cmp_buf[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ovf_flag <= 1'b0;
        else        ovf_flag <= wrap | (ovf_flag & ~ovf_clr);
    end

endmodule

// File: rtl/fpwm_channel.sv
module fpwm_channel
    import fpwm_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             wrap,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] cmp_act,
    input  logic [1:0]       cmode,
    input  logic             flag_clr,
    output logic             match,
    output logic             flag,
    output logic             pwm
);

    pin_state_e pin, pin_nxt;
    cmp_mode_e  cm;

    always_ff @(posedge clk) begin
        if (!rst_n) pin <= PIN_LOW;
        else        pin <= pin_nxt;
    end

    // restart level takes priority over match level
    always_comb begin
        cm      = cmp_mode_e'(cmode);
        match   = step && (count == cmp_act);
        pin_nxt = pin;
        unique case (cm)
            CM_OFF0, CM_OFF1: pin_nxt = PIN_LOW;
            CM_NONINV: begin
                if (wrap)       pin_nxt = PIN_HIGH;
                else if (match) pin_nxt = PIN_LOW;
            end
            CM_INV: begin
                if (wrap)       pin_nxt = PIN_LOW;
                else if (match) pin_nxt = PIN_HIGH;
            end
        endcase
    end

    always_comb begin
        pwm = (pin == PIN_HIGH);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flag <= 1'b0;
        else        flag <= match | (flag & ~flag_clr);
    end

endmodule

// File: rtl/fpwm_timer.sv
module fpwm_timer
    import fpwm_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       clk_sel,
    input  logic [2:0]       wave_mode,
    input  logic [1:0]       cmode_a,
    input  logic [1:0]       cmode_b,
    input  logic             cmp_a_we,
    input  logic [CNT_W-1:0] cmp_a_wdata,
    input  logic             cmp_b_we,
    input  logic [CNT_W-1:0] cmp_b_wdata,
    input  logic             ovf_clr,
    input  logic             cmpa_clr,
    input  logic             cmpb_clr,
    output logic [CNT_W-1:0] count,
    output logic             pwm_a,
    output logic             pwm_b,
    output logic             ovf_flag,
    output logic             cmpa_flag,
    output logic             cmpb_flag
);

    localparam int NCH = 2;

    logic                      tick;
    logic                      step;
    logic                      wrap;
    logic [NCH-1:0]            cmp_we;
    logic [NCH-1:0][CNT_W-1:0] cmp_wdata;
    logic [NCH-1:0][CNT_W-1:0] cmp_act;
    logic [1:0]                cmode_v [NCH];
    logic                      clr_v   [NCH];
    logic                      match   [NCH];
    logic                      flag_v  [NCH];
    logic                      pwm_v   [NCH];

    assign cmp_we     = {cmp_b_we, cmp_a_we};
    assign cmp_wdata  = {cmp_b_wdata, cmp_a_wdata};
    assign cmode_v[0] = cmode_a;
    assign cmode_v[1] = cmode_b;
    assign clr_v[0]   = cmpa_clr;
    assign clr_v[1]   = cmpb_clr;

    fpwm_prescaler i_ps (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (clk_sel),
        .tick  (tick)
    );

    fpwm_counter #(.CNT_W(CNT_W), .NCH(NCH)) i_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .clk_on    (clk_sel != 3'd0),
        .wave_mode (wave_mode),
        .cmp_we    (cmp_we),
        .cmp_wdata (cmp_wdata),
        .ovf_clr   (ovf_clr),
        .count     (count),
        .step      (step),
        .wrap      (wrap),
        .cmp_act   (cmp_act),
        .ovf_flag  (ovf_flag)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        fpwm_channel #(.CNT_W(CNT_W)) i_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .step     (step),
            .wrap     (wrap),
            .count    (count),
            .cmp_act  (cmp_act[i]),
            .cmode    (cmode_v[i]),
            .flag_clr (clr_v[i]),
            .match    (match[i]),
            .flag     (flag_v[i]),
            .pwm      (pwm_v[i])
        );
    end

    assign pwm_a     = pwm_v[0];
    assign pwm_b     = pwm_v[1];
    assign cmpa_flag = flag_v[0];
    assign cmpb_flag = flag_v[1];

endmodule

// File: rtl/fpwm_timer_chk.sv
module fpwm_timer_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       clk_sel,
    input logic [1:0]       cmode_a,
    input logic [1:0]       cmode_b,
    input logic             ovf_clr,
    input logic [CNT_W-1:0] count,
    input logic             wrap,
    input logic             match_a,
    input logic [CNT_W-1:0] act_a,
    input logic             ovf_flag,
    input logic             cmpa_flag,
    input logic             pwm_a,
    input logic             pwm_b
);

    p_wrap_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (count == '0));

    p_ovf_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> ovf_flag);

    p_noninv_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && cmode_a == 2'd2) |=> pwm_a);

    p_inv_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && cmode_b == 2'd3) |=> !pwm_b);

    p_pin_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmode_a < 2'd2) |=> !pwm_a);

    p_match_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        match_a |=> cmpa_flag);

    p_flag_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && ovf_clr && !wrap) |=> !ovf_flag);

    p_buffer_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap |=> $stable(act_a));

    p_stopped_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_sel == 3'd0) |=> $stable(count));

endmodule

bind fpwm_timer fpwm_timer_chk #(.CNT_W(CNT_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clk_sel   (clk_sel),
    .cmode_a   (cmode_a),
    .cmode_b   (cmode_b),
    .ovf_clr   (ovf_clr),
    .count     (count),
    .wrap      (wrap),
    .match_a   (match[0]),
    .act_a     (cmp_act[0]),
    .ovf_flag  (ovf_flag),
    .cmpa_flag (cmpa_flag),
    .pwm_a     (pwm_a),
    .pwm_b     (pwm_b)
);

// File: tb/test_fpwm_timer.sv
module test_fpwm_timer;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [2:0] clk_sel, wave_mode;
    logic [1:0] cmode_a, cmode_b;
    logic       cmp_a_we, cmp_b_we;
    logic [7:0] cmp_a_wdata, cmp_b_wdata;
    logic       ovf_clr, cmpa_clr, cmpb_clr;
    logic [7:0] count;
    logic       pwm_a, pwm_b, ovf_flag, cmpa_flag, cmpb_flag;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    fpwm_timer i_fpwm_timer (
        .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .wave_mode(wave_mode),
        .cmode_a(cmode_a), .cmode_b(cmode_b),
        .cmp_a_we(cmp_a_we), .cmp_a_wdata(cmp_a_wdata),
        .cmp_b_we(cmp_b_we), .cmp_b_wdata(cmp_b_wdata),
        .ovf_clr(ovf_clr), .cmpa_clr(cmpa_clr), .cmpb_clr(cmpb_clr),
        .count(count), .pwm_a(pwm_a), .pwm_b(pwm_b),
        .ovf_flag(ovf_flag), .cmpa_flag(cmpa_flag), .cmpb_flag(cmpb_flag)
    );

    // {wave_mode, cmode_a, cmode_b, cmp_a, cmp_b}
    localparam logic [22:0] VEC [8] = '{
        {3'd3, 2'd2, 2'd2, 8'h80, 8'h40},
        {3'd3, 2'd3, 2'd3, 8'h80, 8'h40},
        {3'd3, 2'd2, 2'd3, 8'h00, 8'hFF},
        {3'd3, 2'd3, 2'd2, 8'h00, 8'hFF},
        {3'd7, 2'd2, 2'd2, 8'h63, 8'h31},
        {3'd7, 2'd3, 2'd2, 8'h1F, 8'h40},
        {3'd3, 2'd0, 2'd1, 8'h80, 8'h40},
        {3'd7, 2'd2, 2'd3, 8'h0A, 8'h00}
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_count(input int v);
        while (int'(count) != v) @(negedge clk);
    endtask

    task automatic wait_restart();
        while (count == 8'd0) @(negedge clk);
        while (count != 8'd0) @(negedge clk);
    endtask

    task automatic set_cmp(input logic [7:0] a, input logic [7:0] b);
        @(negedge clk);
        cmp_a_we = 1'b1; cmp_a_wdata = a;
        cmp_b_we = 1'b1; cmp_b_wdata = b;
        @(negedge clk);
        cmp_a_we = 1'b0; cmp_b_we = 1'b0;
    endtask

    function automatic int exp_high(input logic [1:0] cm, input int cv, input int top);
        int h;
        if (cm < 2'd2) return 0;
        h = (cv >= top) ? top + 1 : cv + 1;
        return (cm == 2'd2) ? h : top + 1 - h;
    endfunction

    function automatic string mode_tag(input logic [1:0] cm);
        if (cm == 2'd2) return "R4";
        if (cm == 2'd3) return "R5";
        return "R6";
    endfunction

    initial begin
        #(20 * 190000);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; clk_sel = 3'd1; wave_mode = 3'd3;
        cmode_a = 2'd2; cmode_b = 2'd2;
        cmp_a_we = 1'b0; cmp_b_we = 1'b0; cmp_a_wdata = '0; cmp_b_wdata = '0;
        ovf_clr = 1'b0; cmpa_clr = 1'b0; cmpb_clr = 1'b0;
        repeat (5) @(negedge clk);
        // R12 reset state
        check("R12 count", int'(count), 0);
        check("R12 flags", int'({ovf_flag, cmpa_flag, cmpb_flag}), 0);
        check("R12 pins", int'({pwm_a, pwm_b}), 0);
        rst_n = 1'b1;

        // vector table: duty and period
        foreach (VEC[k]) begin
            logic [2:0] wm;
            logic [1:0] ca, cb;
            int oa, ob, top, hia, hib, seqbad;
            {wm, ca, cb} = VEC[k][22:16];
            oa = int'(VEC[k][15:8]);
            ob = int'(VEC[k][7:0]);
            top = (wm == 3'd7) ? oa : 255;
            wave_mode = 3'd3; cmode_a = ca; cmode_b = cb;
            set_cmp(oa[7:0], ob[7:0]);
            wait_restart(); wait_restart();
            wave_mode = wm;
            wait_restart(); wait_restart();
            hia = 0; hib = 0; seqbad = 0;
            for (int s = 0; s <= top; s++) begin
                if (int'(count) != s) seqbad++;
                hia += int'(pwm_a);
                hib += int'(pwm_b);
                @(negedge clk);
            end
            check("R1 R2 count sequence", seqbad, 0);
            check("R1 R2 restart after ceiling", int'(count), 0);
            check(mode_tag(ca), hia, exp_high(ca, oa, top));
            check(mode_tag(cb), hib, exp_high(cb, ob, top));
        end

        // directed: overflow flag timing and clear
        wave_mode = 3'd3; cmode_a = 2'd2; cmode_b = 2'd2;
        set_cmp(8'h80, 8'h40);
        wait_restart(); wait_restart();
        wait_count(5);
        ovf_clr = 1'b1; @(negedge clk); ovf_clr = 1'b0;
        check("R8 clear ovf", int'(ovf_flag), 0);
        wait_count(255);
        check("R3 ovf before restart", int'(ovf_flag), 0);
        @(negedge clk);
        check("R3 ovf at restart", int'(ovf_flag), 1);
        // set wins over clear
        wait_count(255);
        ovf_clr = 1'b1; @(negedge clk); ovf_clr = 1'b0;
        check("R8 set beats clear", int'(ovf_flag), 1);
        ovf_clr = 1'b1; @(negedge clk); ovf_clr = 1'b0;
        check("R8 clear after", int'(ovf_flag), 0);

        // match flags
        wait_count(16);
        cmpa_clr = 1'b1; cmpb_clr = 1'b1; @(negedge clk);
        cmpa_clr = 1'b0; cmpb_clr = 1'b0;
        check("R8 clear match flags", int'({cmpa_flag, cmpb_flag}), 0);
        wait_count(128);
        check("R7 flag A before match", int'(cmpa_flag), 0);
        @(negedge clk);
        check("R7 flag A after match", int'(cmpa_flag), 1);
        wait_count(0);
        cmpb_clr = 1'b1; @(negedge clk); cmpb_clr = 1'b0;
        wait_count(64);
        check("R7 flag B before match", int'(cmpb_flag), 0);
        @(negedge clk);
        check("R7 flag B after match", int'(cmpb_flag), 1);

        // holding stage
        wait_count(16);
        set_cmp(8'h20, 8'h40);
        wait_count(80);
        check("R9 old compare still active", int'(pwm_a), 1);
        wait_count(0);
        wait_count(80);
        check("R9 new compare active", int'(pwm_a), 0);

        // divider rates
        begin
            logic [7:0] c1;
            clk_sel = 3'd2; repeat (3) @(negedge clk);
            c1 = count; repeat (80) @(negedge clk);
            check("R10 divide by 8", int'(8'(count - c1)), 10);
            clk_sel = 3'd7; repeat (3) @(negedge clk);
            c1 = count; repeat (2048) @(negedge clk);
            check("R10 divide by 1024", int'(8'(count - c1)), 2);
            clk_sel = 3'd0; @(negedge clk);
            c1 = count; repeat (200) @(negedge clk);
            check("R10 stopped", int'(count), int'(c1));
        end

        // divider restart on select change
        begin
            logic [7:0] c1;
            int early, seen;
            clk_sel = 3'd2; repeat (3) @(negedge clk);
            c1 = count;
            while (count == c1) @(negedge clk);
            repeat (4) @(negedge clk);
            clk_sel = 3'd3;
            c1 = count; early = 0; seen = 0;
            for (int s = 0; s < 31; s++) begin
                @(negedge clk);
                if (count != c1) early++;
            end
            check("R11 no early tick", early, 0);
            for (int s = 0; s < 3; s++) begin
                @(negedge clk);
                if (count != c1) seen = 1;
            end
            check("R11 tick after 32", seen, 1);
        end

        // invalid waveform mode halts
        begin
            logic [7:0] c1;
            clk_sel = 3'd1; repeat (3) @(negedge clk);
            wave_mode = 3'd0; @(negedge clk);
            c1 = count; repeat (50) @(negedge clk);
            check("R2 other mode holds", int'(count), int'(c1));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule